// File: doc/BRIEF.md
# USB Link Status LED Driver

This block turns the state of a full-speed USB device into a pattern on one status LED. The LED hangs from a supply through a resistor and is lit when the chip pulls its pin low. The protocol engine supplies the inputs: a one-cycle strobe for each step of enumeration traffic, a level that is high while a device address is assigned, a one-cycle strobe for each packet that completes without error, a suspend level and a bus-reset level. The block produces a single registered pin-control bit, `led_sink_n_o`. When it is 0, the pad sinks current and the LED is lit. When it is 1, the pad is released and the LED is dark.

The display has three patterns, held in a small state machine. Before an address is assigned, the LED is dark and flashes for a short time on each enumeration strobe. Once an address is assigned, it is lit steadily, and each good packet puts it out for a fixed off-pulse. While the bus is suspended, the LED is dark whatever the other inputs do. Two cycle-count parameters set the flash length and the off-pulse length. With the default values and a 48 MHz clock these are about 25 ms and 100 ms.

Top module: `usb_link_led`

## Requirements
- R1: While `rst` is high and after it is released, `led_sink_n_o` is 1 (LED dark) and the block is in the unaddressed state.
- R2: Unaddressed and not suspended: an `enum_act_i` strobe sampled at edge k drives `led_sink_n_o` to 0 after edge k+1, for exactly BLINK_CYC cycles, after which it returns to 1. With no strobe the pin stays 1.
- R3: `addr_set_i` sampled high at edge k, with `suspend_i` and `bus_rst_i` low, drives `led_sink_n_o` to 0 after edge k+1. It stays 0 while no packet strobe arrives.
- R4: Addressed: a `pkt_ok_i` strobe sampled at edge k drives `led_sink_n_o` to 1 after edge k+1, for exactly PULSE_CYC cycles, after which it returns to 0.
- R5: A `pkt_ok_i` strobe that arrives during an off-pulse restarts it. The pin stays 1 until PULSE_CYC cycles after the edge that follows the newer strobe.
- R6: `enum_act_i` has no effect while addressed, and `pkt_ok_i` has no effect while unaddressed.
- R7: `suspend_i` sampled high at edge k drives `led_sink_n_o` to 1 after edge k+1 and holds it there. Strobes during suspend are discarded. When `suspend_i` is sampled low at edge k with the address still held, the pin is 0 after edge k+1, with no pending off-pulse.
- R8: `bus_rst_i` high, or `addr_set_i` low, sampled at edge k (no suspend) returns the block to the unaddressed state. `led_sink_n_o` is 1 after edge k+1, and later enumeration strobes flash the LED again.
- R9: An `enum_act_i` strobe that arrives during a flash restarts it, so the pin stays 0 until BLINK_CYC cycles after the edge that follows the newer strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running clock |
| rst | input | 1 | Synchronous active-high reset |
| enum_act_i | input | 1 | One-cycle strobe per enumeration transaction |
| addr_set_i | input | 1 | High while a device address is assigned |
| pkt_ok_i | input | 1 | One-cycle strobe per successfully completed packet |
| suspend_i | input | 1 | High while the bus is suspended |
| bus_rst_i | input | 1 | High while a bus reset is signalled |
| led_sink_n_o | output | 1 | Open-drain pin control: 0 sinks current (LED lit), 1 releases the pin |

## Verification
The assertions assume that every input is synchronous to `clk` and already debounced. The strobes are taken to be true single-cycle pulses, and both timer lengths are taken to be at least one cycle. The bench changes every input 1 ns after a rising edge and holds each strobe for exactly one cycle. It also builds the block with short flash and off-pulse lengths, so each timer expires inside the test. During a bus reset the bench keeps `addr_set_i` in the state a protocol engine would hold it in.

// File: rtl/usb_link_led_pkg.sv
package usb_link_led_pkg;

  typedef enum logic [1:0] {
    LNK_IDLE  = 2'd0,   // no address: flash on enumeration traffic
    LNK_LIVE  = 2'd1,   // address held: steady on, off-pulse per packet
    LNK_SLEEP = 2'd2    // suspended: dark
  } lnk_state_t;

endpackage

// File: rtl/led_hold_timer.sv
module led_hold_timer #(
  parameter int unsigned LEN = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic load_i,
  input  logic clear_i,
  output logic busy_o
);
  localparam int unsigned CW = (LEN < 1) ? 1 : $clog2(LEN + 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst || clear_i) begin
      cnt_q <= '0;
    end else if (load_i) begin
      cnt_q <= CW'(LEN);
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  assign busy_o = (cnt_q != '0);

  // R5 / R9: a new strobe always reloads the full length
  a_r5_reload: assert property (@(posedge clk) disable iff (rst)
    (load_i && !clear_i) |=> (cnt_q == CW'(LEN)));

  // R2 / R4: the count falls by one per cycle and never wraps
  a_r4_count_down: assert property (@(posedge clk) disable iff (rst)
    (cnt_q != '0 && !load_i && !clear_i) |=> (cnt_q == $past(cnt_q) - CW'(1)));

  a_r4_no_wrap: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == '0 && !load_i) |=> (cnt_q == '0));

endmodule

// File: rtl/link_fsm.sv
module link_fsm
  import usb_link_led_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       addr_set_i,
  input  logic       bus_rst_i,
  input  logic       suspend_i,
  output lnk_state_t st_o
);
  lnk_state_t st_q, st_d;
  logic       addr_ok;

  assign addr_ok = addr_set_i && !bus_rst_i;

  always_comb begin
    st_d = st_q;
    if (suspend_i) begin
      st_d = LNK_SLEEP;
    end else begin
      unique case (st_q)
        LNK_IDLE:  st_d = addr_ok ? LNK_LIVE : LNK_IDLE;
        LNK_LIVE:  st_d = addr_ok ? LNK_LIVE : LNK_IDLE;
        LNK_SLEEP: st_d = addr_ok ? LNK_LIVE : LNK_IDLE;
        default:   st_d = LNK_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) st_q <= LNK_IDLE;
    else     st_q <= st_d;
  end

  assign st_o = st_q;

  a_r7_sleep_entry: assert property (@(posedge clk) disable iff (rst)
    suspend_i |=> (st_q == LNK_SLEEP));

  a_r8_drop_addr: assert property (@(posedge clk) disable iff (rst)
    (!suspend_i && (bus_rst_i || !addr_set_i)) |=> (st_q == LNK_IDLE));

  a_r3_enter_live: assert property (@(posedge clk) disable iff (rst)
    (!suspend_i && !bus_rst_i && addr_set_i) |=> (st_q == LNK_LIVE));

endmodule

// File: rtl/usb_link_led.sv
module usb_link_led
  import usb_link_led_pkg::*;
#(
  parameter int unsigned BLINK_CYC = 1200000,
  parameter int unsigned PULSE_CYC = 4800000
) (
  input  logic clk,
  input  logic rst,
  input  logic enum_act_i,
  input  logic addr_set_i,
  input  logic pkt_ok_i,
  input  logic suspend_i,
  input  logic bus_rst_i,
  output logic led_sink_n_o
);
  lnk_state_t st;
  logic       blink_busy, pulse_busy;
  logic       lit_d, led_n_q;

  link_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .addr_set_i (addr_set_i),
    .bus_rst_i  (bus_rst_i),
    .suspend_i  (suspend_i),
    .st_o       (st)
  );

  // flash timer: only meaningful while unaddressed
  led_hold_timer #(.LEN(BLINK_CYC)) u_blink (
    .clk     (clk),
    .rst     (rst),
    .load_i  (enum_act_i && st == LNK_IDLE),
    .clear_i (st != LNK_IDLE),
    .busy_o  (blink_busy)
  );

  // off-pulse timer: only meaningful while addressed
  led_hold_timer #(.LEN(PULSE_CYC)) u_pulse (
    .clk     (clk),
    .rst     (rst),
    .load_i  (pkt_ok_i && st == LNK_LIVE),
    .clear_i (st != LNK_LIVE),
    .busy_o  (pulse_busy)
  );

  always_comb begin
    unique case (st)
      LNK_IDLE: lit_d = blink_busy;
      LNK_LIVE: lit_d = !pulse_busy;
      default:  lit_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) led_n_q <= 1'b1;
    else     led_n_q <= !lit_d;
  end

  assign led_sink_n_o = led_n_q;

  a_r1_reset_dark: assert property (@(posedge clk)
    rst |=> led_n_q);

  a_r7_sleep_dark: assert property (@(posedge clk) disable iff (rst)
    (st == LNK_SLEEP) |=> led_n_q);

  a_r3_steady_on: assert property (@(posedge clk) disable iff (rst)
    (st == LNK_LIVE && !pulse_busy) |=> !led_n_q);

  a_r2_idle_dark: assert property (@(posedge clk) disable iff (rst)
    (st == LNK_IDLE && !blink_busy) |=> led_n_q);

endmodule

// File: tb/usb_link_led_tb_top.sv
`timescale 1ns/1ps
module usb_link_led_tb_top;
  localparam int unsigned BLINK = 6;
  localparam int unsigned PULSE = 10;

  logic clk = 1'b0;
  logic rst, enum_act, addr_set, pkt_ok, suspend, bus_rst;
  logic led_n;
  int   n_chk = 0;
  int   n_bad = 0;
  bit   done  = 1'b0;

  always #4 clk = ~clk;

  usb_link_led #(.BLINK_CYC(BLINK), .PULSE_CYC(PULSE)) dut_i (
    .clk          (clk),
    .rst          (rst),
    .enum_act_i   (enum_act),
    .addr_set_i   (addr_set),
    .pkt_ok_i     (pkt_ok),
    .suspend_i    (suspend),
    .bus_rst_i    (bus_rst),
    .led_sink_n_o (led_n)
  );

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic check(input logic exp, input string tag);
    n_chk++;
    if (led_n !== exp) begin
      n_bad++;
      $display("FAIL %s: led_sink_n_o=%0b expected %0b", tag, led_n, exp);
    end
  endtask

  task automatic strobe_enum();
    enum_act = 1'b1; step(1); enum_act = 1'b0;
  endtask

  task automatic strobe_pkt();
    pkt_ok = 1'b1; step(1); pkt_ok = 1'b0;
  endtask

  task automatic t_reset();
    rst = 1'b1; enum_act = 0; addr_set = 0; pkt_ok = 0; suspend = 0; bus_rst = 0;
    step(3);
    check(1'b1, "R1 during reset");
    rst = 1'b0;
    step(4);
    check(1'b1, "R1 after reset");
  endtask

  task automatic t_blink();
    strobe_enum();
    step(1);         check(1'b0, "R2 flash start");
    step(BLINK - 1); check(1'b0, "R2 flash last cycle");
    step(1);         check(1'b1, "R2 flash end");
    step(5);         check(1'b1, "R2 dark without strobe");
  endtask

  task automatic t_blink_restart();
    strobe_enum();
    step(3);
    strobe_enum();
    step(BLINK);     check(1'b0, "R9 flash restarted");
    step(1);         check(1'b1, "R9 flash end after restart");
  endtask

  task automatic t_pkt_idle();
    strobe_pkt();
    step(1);         check(1'b1, "R6 packet ignored unaddressed");
    step(PULSE);     check(1'b1, "R6 still dark");
  endtask

  task automatic t_address();
    addr_set = 1'b1;
    step(1);
    step(1);         check(1'b0, "R3 lit after address");
    step(20);        check(1'b0, "R3 steady");
  endtask

  task automatic t_pulse();
    strobe_pkt();
    step(1);         check(1'b1, "R4 off-pulse start");
    step(PULSE - 1); check(1'b1, "R4 off-pulse last cycle");
    step(1);         check(1'b0, "R4 back on");
  endtask

  task automatic t_pulse_restart();
    strobe_pkt();
    step(4);
    strobe_pkt();
    step(PULSE);     check(1'b1, "R5 off-pulse restarted");
    step(1);         check(1'b0, "R5 on after restarted pulse");
  endtask

  task automatic t_enum_live();
    strobe_enum();
    step(1);         check(1'b0, "R6 enum ignored addressed");
    step(BLINK + 2); check(1'b0, "R6 still lit");
  endtask

  task automatic t_suspend();
    suspend = 1'b1;
    step(1);
    step(1);         check(1'b1, "R7 dark in suspend");
    strobe_pkt();
    strobe_enum();
    step(PULSE);     check(1'b1, "R7 dark held");
    suspend = 1'b0;
    step(1);
    step(1);         check(1'b0, "R7 lit on resume");
    step(PULSE + 2); check(1'b0, "R7 no stale pulse");
  endtask

  task automatic t_unaddr();
    bus_rst = 1'b1;
    step(1);
    step(1);         check(1'b1, "R8 dark in bus reset");
    step(2);         check(1'b1, "R8 held dark");
    bus_rst = 1'b0; addr_set = 1'b0;
    step(3);         check(1'b1, "R8 unaddressed dark");
    strobe_enum();
    step(1);         check(1'b0, "R8 flash after unaddress");
    step(BLINK);     check(1'b1, "R8 flash end");
    addr_set = 1'b1;
    step(3);         check(1'b0, "R8 re-addressed");
    addr_set = 1'b0;
    step(1);
    step(1);         check(1'b1, "R8 address dropped");
  endtask

  initial begin
    t_reset();
    t_blink();
    t_blink_restart();
    t_pkt_idle();
    t_address();
    t_pulse();
    t_pulse_restart();
    t_enum_live();
    t_suspend();
    t_unaddr();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

endmodule